// File: doc/BRIEF.md
# Block-Addressable Serial Read Port Controller

This block governs the read side of a field memory organised as 6144 blocks of 40 words. It runs on its own read clock and drives the word address of the memory array. Each read reset returns the pointer to word 0, and the pointer then steps through the memory one word per cycle while the read enable is high.

A short control pattern on the read-enable and output-enable inputs, given right after a read reset, switches the port into random block access. A 13-bit block number then arrives serially on one pin, a fixed latency follows, and reading restarts at the first word of that block. A data-valid flag shows when the address points at wanted data. A separate drive-enable output, taken from the output enable, lets the data pins float without disturbing the pointer.

Top module: `rdp_read_ctrl`

## Requirements
- R1: After the asynchronous reset `rd_addr` is 0 and `data_valid` and `drive_en` are 0. The pointer does not move, whatever `rd_en` does, until the first read reset.
- R2: A rising `rclk` edge that samples `rd_rst_n` low sets `rd_addr` to 0 and `data_valid` to 1 after that edge, whatever state the port was in.
- R3: Random block access is entered only when the four edges after a read reset sample (`rd_en`,`out_en`) as (0,1), then (1,1), (1,1) and (1,1). Once the fourth matching edge is sampled, `data_valid` is 0. Any other value at any of these edges leaves the port in sequential mode with `data_valid` at 1.
- R4: In sequential mode or after the start block has been loaded, each edge with `rd_en` high adds 1 to `rd_addr`, and each edge with `rd_en` low leaves it unchanged.
- R5: `drive_en` equals the value `out_en` had at the previous rising edge, whatever the pointer and mode are doing.
- R6: After random mode has been entered, the next 13 edges sample `blk_sdi` as the block number, least significant bit first.
- R7: The 20 edges after the last address bit are latency. Through the shifting and the latency `data_valid` is 0 and `rd_addr` is frozen even when `rd_en` is high. After the 20th latency edge, `rd_addr` is block×40 and `data_valid` is 1, and it stays 1 until the next read reset.
- R8: Advancing from the last word, 245759, gives `rd_addr` 0.
- R9: A serial block number of 6144 or more starts reading at block 0, that is at `rd_addr` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rclk | input | 1 | Read clock; everything is sampled on its rising edge |
| arst_n | input | 1 | Asynchronous reset, active low |
| rd_rst_n | input | 1 | Read reset, active low, sampled on the clock |
| rd_en | input | 1 | Pointer advance enable; also part of the mode pattern |
| out_en | input | 1 | Output enable; also part of the mode pattern |
| blk_sdi | input | 1 | Serial block number, least significant bit first |
| rd_addr | output | 18 | Word address driven to the memory array |
| data_valid | output | 1 | Address points at wanted data |
| drive_en | output | 1 | Data pins driven when 1 and floating when 0 |

## Verification
Sequential reading is driven from a table of read-enable and output-enable combinations. The table shows that the pointer responds only to read enable and the drive output only to output enable. Random access is tried with a small block number, the last block and an out-of-range number, so a bit-order fault, a wrong multiply by 40, a missing clamp or a missing wrap each gives a different address. The entry pattern is also given with a wrong value in one slot, and the latency count is checked one edge before and at the load, so an early or late start is caught.

// File: rtl/rdp_pkg.sv
package rdp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_DET  = 3'd1,
        ST_LOAD = 3'd2,
        ST_LAT  = 3'd3,
        ST_RUN  = 3'd4
    } rdp_state_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/rdp_mode_fsm.sv
module rdp_mode_fsm
    import rdp_pkg::*;
#(
    parameter int ADDR_BITS = 13,
    parameter int LATENCY   = 20
) (
    input  logic clk,
    input  logic arst_n,
    input  logic rst_req,
    input  logic rd_en,
    input  logic out_en,
    output logic shift_en,
    output logic load_go,
    output logic adv_en,
    output logic valid
);
    localparam int CNT_W = $clog2(max3(LATENCY, ADDR_BITS, 4) + 1);
    localparam logic [CNT_W-1:0] SHIFT_LAST = CNT_W'(ADDR_BITS - 1);
    localparam logic [CNT_W-1:0] LAT_LAST   = CNT_W'(LATENCY - 1);
    localparam logic [CNT_W-1:0] DET_LAST   = CNT_W'(3);

    typedef struct packed {
        rdp_state_e       state;
        logic [CNT_W-1:0] cnt;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        if (rst_req) begin
            fsm_d.state = ST_DET;
            fsm_d.cnt   = '0;
        end else begin
            unique case (fsm_q.state)
                ST_IDLE: fsm_d = fsm_q;
                ST_DET: begin
                    if (fsm_q.cnt == '0) begin
                        if (!rd_en && out_en) fsm_d.cnt = fsm_q.cnt + 1'b1;
                        else                  fsm_d.state = ST_RUN;
                    end else if (rd_en && out_en) begin
                        if (fsm_q.cnt == DET_LAST) begin
                            fsm_d.state = ST_LOAD;
                            fsm_d.cnt   = '0;
                        end else begin
                            fsm_d.cnt = fsm_q.cnt + 1'b1;
                        end
                    end else begin
                        fsm_d.state = ST_RUN;
                    end
                end
                ST_LOAD: begin
                    if (fsm_q.cnt == SHIFT_LAST) begin
                        fsm_d.state = ST_LAT;
                        fsm_d.cnt   = '0;
                    end else begin
                        fsm_d.cnt = fsm_q.cnt + 1'b1;
                    end
                end
                ST_LAT: begin
                    if (fsm_q.cnt == LAT_LAST) begin
                        fsm_d.state = ST_RUN;
                        fsm_d.cnt   = '0;
                    end else begin
                        fsm_d.cnt = fsm_q.cnt + 1'b1;
                    end
                end
                ST_RUN:  fsm_d = fsm_q;
                default: fsm_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            fsm_q.state <= ST_IDLE;
            fsm_q.cnt   <= '0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign valid    = (fsm_q.state == ST_DET) || (fsm_q.state == ST_RUN);
    assign shift_en = (fsm_q.state == ST_LOAD) && !rst_req;
    assign load_go  = (fsm_q.state == ST_LAT) && (fsm_q.cnt == LAT_LAST) && !rst_req;
    assign adv_en   = valid && rd_en && !rst_req;

    AST_LOAD_EXCL: assert property (@(posedge clk) disable iff (!arst_n)
        $onehot0({shift_en, load_go, adv_en})) else $error("AST_LOAD_EXCL"); // R6
    AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!arst_n)
        (valid && !rst_req && !(fsm_q.state == ST_DET)) |=> valid) else $error("AST_VALID_STICKY"); // R7
    AST_SHIFT_TO_LAT: assert property (@(posedge clk) disable iff (!arst_n)
        (shift_en && fsm_q.cnt == SHIFT_LAST) |=> !valid) else $error("AST_SHIFT_TO_LAT"); // R7
    AST_GO_VALID: assert property (@(posedge clk) disable iff (!arst_n)
        load_go |=> valid) else $error("AST_GO_VALID"); // R7
endmodule

// File: rtl/rdp_blk_shift.sv
module rdp_blk_shift #(
    parameter int ADDR_BITS  = 13,
    parameter int NUM_BLKS   = 6144,
    parameter int BLK_WORDS  = 40,
    parameter int ADDR_W     = 18
) (
    input  logic              clk,
    input  logic              arst_n,
    input  logic              shift_en,
    input  logic              sdi,
    output logic [ADDR_W-1:0] blk_start
);
    localparam logic [ADDR_BITS:0]  BLK_LIM = (ADDR_BITS + 1)'(NUM_BLKS);
    localparam logic [ADDR_W-1:0]   WORDS_W = ADDR_W'(BLK_WORDS);
    localparam logic [ADDR_W-1:0]   TOTAL_W = ADDR_W'(NUM_BLKS * BLK_WORDS - 1);

    typedef struct packed {
        logic [ADDR_BITS-1:0] sr;
    } shf_t;

    shf_t shf_d, shf_q;

    always_comb begin
        shf_d = shf_q;
        if (shift_en) shf_d.sr = {sdi, shf_q.sr[ADDR_BITS-1:1]};
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) shf_q.sr <= '0;
        else         shf_q    <= shf_d;
    end

    always_comb begin
        if ({1'b0, shf_q.sr} < BLK_LIM) blk_start = ADDR_W'(shf_q.sr) * WORDS_W;
        else                            blk_start = '0;
    end

    AST_START_RANGE: assert property (@(posedge clk) disable iff (!arst_n)
        blk_start <= TOTAL_W) else $error("AST_START_RANGE"); // R9
endmodule

// File: rtl/rdp_addr_ctr.sv
module rdp_addr_ctr #(
    parameter int ADDR_W    = 18,
    parameter int TOTAL     = 245760
) (
    input  logic              clk,
    input  logic              arst_n,
    input  logic              clr,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              adv,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(TOTAL - 1);

    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (clr)       ctr_d.ptr = '0;
        else if (load) ctr_d.ptr = load_val;
        else if (adv)  ctr_d.ptr = (ctr_q.ptr == LAST) ? '0 : ctr_q.ptr + 1'b1;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) ctr_q.ptr <= '0;
        else         ctr_q     <= ctr_d;
    end

    assign addr = ctr_q.ptr;

    AST_HOLD: assert property (@(posedge clk) disable iff (!arst_n)
        (!clr && !load && !adv) |=> $stable(addr)) else $error("AST_HOLD"); // R4
    AST_STEP: assert property (@(posedge clk) disable iff (!arst_n)
        (!clr && !load && adv && addr != LAST) |=> (addr == $past(addr) + 1'b1)) else $error("AST_STEP"); // R4
    AST_WRAP: assert property (@(posedge clk) disable iff (!arst_n)
        (!clr && !load && adv && addr == LAST) |=> (addr == '0)) else $error("AST_WRAP"); // R8
endmodule

// File: rtl/rdp_read_ctrl.sv
module rdp_read_ctrl #(
    parameter int NUM_BLKS  = 6144,
    parameter int BLK_WORDS = 40,
    parameter int ADDR_BITS = 13,
    parameter int LATENCY   = 20,
    parameter int ADDR_W    = $clog2(NUM_BLKS * BLK_WORDS)
) (
    input  logic              rclk,
    input  logic              arst_n,
    input  logic              rd_rst_n,
    input  logic              rd_en,
    input  logic              out_en,
    input  logic              blk_sdi,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              data_valid,
    output logic              drive_en
);
    localparam int TOTAL = NUM_BLKS * BLK_WORDS;

    logic              rst_req;
    logic              shift_en;
    logic              load_go;
    logic              adv_en;
    logic [ADDR_W-1:0] blk_start;
    logic              drv_d, drv_q;

    assign rst_req = !rd_rst_n;

    rdp_mode_fsm #(
        .ADDR_BITS (ADDR_BITS),
        .LATENCY   (LATENCY)
    ) u_fsm (
        .clk      (rclk),
        .arst_n   (arst_n),
        .rst_req  (rst_req),
        .rd_en    (rd_en),
        .out_en   (out_en),
        .shift_en (shift_en),
        .load_go  (load_go),
        .adv_en   (adv_en),
        .valid    (data_valid)
    );

    rdp_blk_shift #(
        .ADDR_BITS (ADDR_BITS),
        .NUM_BLKS  (NUM_BLKS),
        .BLK_WORDS (BLK_WORDS),
        .ADDR_W    (ADDR_W)
    ) u_shift (
        .clk       (rclk),
        .arst_n    (arst_n),
        .shift_en  (shift_en),
        .sdi       (blk_sdi),
        .blk_start (blk_start)
    );

    rdp_addr_ctr #(
        .ADDR_W (ADDR_W),
        .TOTAL  (TOTAL)
    ) u_ctr (
        .clk      (rclk),
        .arst_n   (arst_n),
        .clr      (rst_req),
        .load     (load_go),
        .load_val (blk_start),
        .adv      (adv_en),
        .addr     (rd_addr)
    );

    always_comb drv_d = out_en;

    always_ff @(posedge rclk or negedge arst_n) begin
        if (!arst_n) drv_q <= 1'b0;
        else         drv_q <= drv_d;
    end

    assign drive_en = drv_q;

    AST_READ_RESET: assert property (@(posedge rclk) disable iff (!arst_n)
        rst_req |=> (rd_addr == '0 && data_valid)) else $error("AST_READ_RESET"); // R2
    AST_DRIVE_FOLLOW: assert property (@(posedge rclk) disable iff (!arst_n)
        $rose(out_en) |=> drive_en) else $error("AST_DRIVE_FOLLOW"); // R5
    AST_DRIVE_OFF: assert property (@(posedge rclk) disable iff (!arst_n)
        $fell(out_en) |=> !drive_en) else $error("AST_DRIVE_OFF"); // R5
endmodule

// File: tb/rdp_read_ctrl_tb_top.sv
`timescale 1ns/1ps
module rdp_read_ctrl_tb_top;
    localparam int ADDR_W = 18;
    localparam int LAST   = 6144 * 40 - 1;

    logic              rclk = 1'b0;
    logic              arst_n = 1'b0;
    logic              rd_rst_n = 1'b1;
    logic              rd_en = 1'b0;
    logic              out_en = 1'b0;
    logic              blk_sdi = 1'b0;
    logic [ADDR_W-1:0] rd_addr;
    logic              data_valid;
    logic              drive_en;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 rclk = ~rclk;

    rdp_read_ctrl dut_i (
        .rclk       (rclk),
        .arst_n     (arst_n),
        .rd_rst_n   (rd_rst_n),
        .rd_en      (rd_en),
        .out_en     (out_en),
        .blk_sdi    (blk_sdi),
        .rd_addr    (rd_addr),
        .data_valid (data_valid),
        .drive_en   (drive_en)
    );

    // {rd_en, out_en, expected rd_addr, expected drive_en}
    localparam logic [20:0] VEC [8] = '{
        {1'b1, 1'b1, 18'd1, 1'b1},
        {1'b1, 1'b0, 18'd2, 1'b0},
        {1'b0, 1'b0, 18'd2, 1'b0},
        {1'b0, 1'b1, 18'd2, 1'b1},
        {1'b1, 1'b1, 18'd3, 1'b1},
        {1'b1, 1'b0, 18'd4, 1'b0},
        {1'b0, 1'b1, 18'd4, 1'b1},
        {1'b1, 1'b1, 18'd5, 1'b1}
    };

    task automatic tick();
        @(posedge rclk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic read_reset();
        rd_rst_n = 1'b0;
        tick();
        rd_rst_n = 1'b1;
    endtask

    // Enter random mode and shift blk; rd_en is kept high to prove the freeze.
    task automatic enter_random(input int blk);
        read_reset();
        rd_en = 1'b0; out_en = 1'b1; tick();
        rd_en = 1'b1; out_en = 1'b1; tick(); tick(); tick();
        chk("R3 valid low on entry", int'(data_valid), 0);
        for (int i = 0; i < 13; i++) begin
            blk_sdi = blk[i];
            tick();
        end
        blk_sdi = 1'b0;
        for (int i = 0; i < 19; i++) tick();
        chk("R7 valid low before last latency edge", int'(data_valid), 0);
        chk("R7 pointer frozen", int'(rd_addr), 3);
        tick();
        chk("R7 valid after latency", int'(data_valid), 1);
    endtask

    initial begin
        #4;
        chk("R1 reset addr", int'(rd_addr), 0);
        chk("R1 reset valid", int'(data_valid), 0);
        chk("R1 reset drive", int'(drive_en), 0);
        arst_n = 1'b1;
        rd_en = 1'b1;
        tick(); tick();
        chk("R1 no move before read reset", int'(rd_addr), 0);

        rd_en = 1'b1; out_en = 1'b1; rd_rst_n = 1'b0;
        tick();
        rd_rst_n = 1'b1;
        chk("R2 read reset addr", int'(rd_addr), 0);
        chk("R2 read reset valid", int'(data_valid), 1);

        for (int i = 0; i < 8; i++) begin
            rd_en  = VEC[i][20];
            out_en = VEC[i][19];
            tick();
            chk("R4 table addr", int'(rd_addr), int'(VEC[i][18:1]));
            chk("R5 table drive", int'(drive_en), int'(VEC[i][0]));
            chk("R4 table valid", int'(data_valid), 1);
        end

        // R3: broken pattern stays sequential
        read_reset();
        rd_en = 1'b0; out_en = 1'b1; tick();
        rd_en = 1'b1; out_en = 1'b0; tick();
        rd_en = 1'b1; out_en = 1'b1; tick(); tick(); tick();
        chk("R3 broken pattern valid", int'(data_valid), 1);
        chk("R3 broken pattern addr", int'(rd_addr), 4);

        // R6/R7: block 5 -> word 200, then advance
        enter_random(5);
        chk("R6 start of block 5", int'(rd_addr), 200);
        tick();
        chk("R7 advance after load", int'(rd_addr), 201);
        rd_en = 1'b0; tick(); tick();
        chk("R7 valid stays high", int'(data_valid), 1);
        chk("R4 hold after load", int'(rd_addr), 201);

        // R8: last block and wrap
        enter_random(6143);
        chk("R6 start of last block", int'(rd_addr), LAST - 39);
        for (int i = 0; i < 39; i++) tick();
        chk("R8 last word", int'(rd_addr), LAST);
        tick();
        chk("R8 wrap to zero", int'(rd_addr), 0);

        // R9: out-of-range block
        enter_random(8000);
        chk("R9 out of range block", int'(rd_addr), 0);

        // R2: read reset mid-run
        tick(); tick();
        read_reset();
        chk("R2 reset mid-run", int'(rd_addr), 0);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 5000; c++) begin
            @(posedge rclk);
            if (done) break;
        end
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule